// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block pairs one free-running 64-bit up-counter with a set of comparator channels, three by default. Software programs it through a plain 32-bit register bus: writes land on the rising clock edge, and reads are combinational from the current address. To arm a channel, software reads the counter, adds a delta and writes the sum into that channel's compare register. When the running counter reaches that value, the channel latches its status bit.

While a channel's status bit is set, the channel holds a level interrupt on one of several route outputs. Software picks the route by number in the channel configuration. Each channel also reports a read-only bitmap of the routes it is allowed to drive. A route outside that bitmap yields no output. The interrupt stays asserted until software writes a one to the channel's status bit.

A global register starts and stops the counter. It also holds a stored-only compatibility bit that has no effect on the block. Each channel can compare either all 64 bits or only the low 32 bits of the counter, in which case the match point wraps.

Top module: `evt_timer_top`

## Requirements
- R1: Address 0x000 reads a constant identifier. Bits [7:0] = 0x01, bits [12:8] = channel count minus one (2 by default), and all other bits are 0.
- R2: The global register is at 0x010. While its bit 0 is 1, the counter advances by exactly one per clock. While it is 0, the counter holds its value.
- R3: Bit 1 of the global register reads back as written and has no effect on counting, status or route outputs.
- R4: The counter low word is at 0x0F0 and the high word is at 0x0F4. Each can be read and written, and carries propagate from the low word into the high word. Writing 0 to both halves returns the counter to 0.
- R5: Channel n occupies addresses from 0x100 + 0x20*n. The configuration word is at +0x0, and only these bits can be written: bit 1 (level), bit 2 (enable), bit 5 (32-bit compare) and bits [13:9] (route number). The read-only route bitmap is at +0x4 and reads 0x000000E6 by default, which allows routes 1, 2, 5, 6 and 7. Writes to +0x4 are ignored. The compare word is split into a low half at +0x8 and a high half at +0xC.
- R6: Take a channel that is enabled and set to 64-bit compare. If the running counter holds a value equal to its compare register during a cycle, the channel's status bit is 1 from the next clock edge onward.
- R7: With bit 5 set, a channel compares only the low 32 bits of the counter against the low 32 bits of its compare register. It ignores the upper halves, so a match can occur after the low word wraps. With bit 5 clear, a mismatch in the upper halves prevents the match.
- R8: The status register is at 0x020, with bit n for channel n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A status bit changes only through a match or a one-write to that bit.
- R9: A channel whose enable bit is 0 never sets its status bit. Clearing the enable bit keeps the stored compare value and route number.
- R10: Route output r is 1 when some channel has its status bit set, has route number r selected, and has bitmap bit r set. The output stays 1 until that status bit is cleared, including after the counter stops.
- R11: If a channel selects a route number whose bitmap bit is 0, that channel drives no route output, even while its status bit is set.
- R12: After reset, the counter, global register, status register and every channel configuration and compare register read 0, and all route outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_route | output | 8 | Level interrupt outputs, one per route number |

## Verification
Register writes take effect at the rising edge where the strobe is high, and reads reflect the new state at once. The counter advances first at the edge after the edge that writes the enable. A match is evaluated on the registered counter value and lands in the status register one edge later. As a result, arming a compare value three counts ahead of a stopped counter and then enabling the counter makes the status bit and its route output appear at the fourth edge after the enabling write. The bench drives inputs and samples outputs only just after falling edges. It checks that the status is still clear at the third edge and set at the fourth, so a lost or extra register stage shows up as a failure.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    // global register addresses
    localparam int ADR_ID     = 'h000;
    localparam int ADR_GCFG   = 'h010;
    localparam int ADR_STS    = 'h020;
    localparam int ADR_CNT_LO = 'h0F0;
    localparam int ADR_CNT_HI = 'h0F4;

    // per-channel window
    localparam int CH_BASE    = 'h100;
    localparam int CH_STRIDE  = 'h20;
    localparam int CH_OFS_CFG = 'h0;
    localparam int CH_OFS_CAP = 'h4;
    localparam int CH_OFS_CLO = 'h8;
    localparam int CH_OFS_CHI = 'hC;

    // channel configuration field positions
    localparam int CFG_LVL_BIT = 1;
    localparam int CFG_EN_BIT  = 2;
    localparam int CFG_M32_BIT = 5;
    localparam int CFG_RT_LSB  = 9;
    localparam int RT_W        = 5;

    localparam logic [7:0] ID_REV = 8'h01;

    typedef struct packed {
        logic            m32;
        logic            en;
        logic            lvl;
        logic [RT_W-1:0] route;
    } chcfg_t;

    function automatic logic [31:0] cfg_pack(chcfg_t c);
        logic [31:0] w;
        w = '0;
        w[CFG_LVL_BIT] = c.lvl;
        w[CFG_EN_BIT]  = c.en;
        w[CFG_M32_BIT] = c.m32;
        w[CFG_RT_LSB +: RT_W] = c.route;
        return w;
    endfunction

    function automatic chcfg_t cfg_unpack(logic [31:0] w);
        chcfg_t c;
        c.lvl   = w[CFG_LVL_BIT];
        c.en    = w[CFG_EN_BIT];
        c.m32   = w[CFG_M32_BIT];
        c.route = w[CFG_RT_LSB +: RT_W];
        return c;
    endfunction

endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
    parameter int HALF = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF-1:0]   wdata,
    output logic [2*HALF-1:0] cnt_q
);
    localparam int CW = 2 * HALF;

    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (run)
            cnt_d = cnt_q + CW'(1);
        if (wr_lo)
            cnt_d[HALF-1:0] = wdata;
        if (wr_hi)
            cnt_d[CW-1:HALF] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_timer_pkg::*;
#(
    parameter int HALF = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [2*HALF-1:0] cnt,
    input  logic              wr_cfg,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [31:0]       wdata,
    output chcfg_t            cfg,
    output logic [2*HALF-1:0] cmp,
    output logic              hit
);
    localparam int CW = 2 * HALF;

    typedef struct packed {
        chcfg_t        cfg;
        logic [CW-1:0] cmp;
    } chst_t;

    chst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cfg)
            st_d.cfg = cfg_unpack(wdata);
        if (wr_lo)
            st_d.cmp[HALF-1:0] = wdata[HALF-1:0];
        if (wr_hi)
            st_d.cmp[CW-1:HALF] = wdata[HALF-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    logic eq_lo, eq_hi;
    assign eq_lo = (cnt[HALF-1:0] == st_q.cmp[HALF-1:0]);
    assign eq_hi = (cnt[CW-1:HALF] == st_q.cmp[CW-1:HALF]);
    assign hit   = run && st_q.cfg.en && eq_lo && (st_q.cfg.m32 || eq_hi);
    assign cfg   = st_q.cfg;
    assign cmp   = st_q.cmp;
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route
    import evt_timer_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int NROUTE = 8
) (
    input  logic [NCH-1:0]      sts,
    input  logic [NCH*RT_W-1:0] routes,
    input  logic [NROUTE-1:0]   cap,
    output logic [NROUTE-1:0]   irq
);
    always_comb begin
        irq = '0;
        for (int r = 0; r < NROUTE; r++) begin
            for (int n = 0; n < NCH; n++) begin
                if (sts[n] && cap[r] && (routes[n*RT_W +: RT_W] == RT_W'(r)))
                    irq[r] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
    import evt_timer_pkg::*;
#(
    parameter int          NCH      = 3,
    parameter int          NROUTE   = 8,
    parameter int          AW       = 12,
    parameter logic [31:0] CAP_MASK = 32'h0000_00E6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NROUTE-1:0] irq_route
);
    localparam int          HALF     = 32;
    localparam logic [31:0] RT_LIMIT = (NROUTE >= 32) ? 32'hFFFF_FFFF
                                       : 32'((64'd1 << NROUTE) - 64'd1);
    localparam logic [31:0] CAP_EFF  = CAP_MASK & RT_LIMIT;
    localparam logic [31:0] ID_WORD  = {19'd0, 5'(NCH - 1), ID_REV};

    typedef struct packed {
        logic [NCH-1:0] sts;
        logic           legacy;
        logic           en;
    } gstate_t;

    gstate_t st_d, st_q;

    logic                 wr_gcfg, wr_sts, cnt_wr_lo, cnt_wr_hi, run;
    logic [2*HALF-1:0]    cnt_val;
    logic [NCH-1:0]       hit, sts_vec;
    logic [NCH*RT_W-1:0]  ch_route;
    chcfg_t               ch_cfg [NCH];
    logic [2*HALF-1:0]    ch_cmp [NCH];

    assign wr_gcfg   = bus_we && (bus_addr == AW'(ADR_GCFG));
    assign wr_sts    = bus_we && (bus_addr == AW'(ADR_STS));
    assign cnt_wr_lo = bus_we && (bus_addr == AW'(ADR_CNT_LO));
    assign cnt_wr_hi = bus_we && (bus_addr == AW'(ADR_CNT_HI));
    assign run       = st_q.en;
    assign sts_vec   = st_q.sts;

    evt_main_counter #(.HALF(HALF)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .wr_lo (cnt_wr_lo),
        .wr_hi (cnt_wr_hi),
        .wdata (bus_wdata),
        .cnt_q (cnt_val)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int BASE = CH_BASE + g * CH_STRIDE;
        logic w_cfg, w_lo, w_hi;
        assign w_cfg = bus_we && (bus_addr == AW'(BASE + CH_OFS_CFG));
        assign w_lo  = bus_we && (bus_addr == AW'(BASE + CH_OFS_CLO));
        assign w_hi  = bus_we && (bus_addr == AW'(BASE + CH_OFS_CHI));

        evt_cmp_channel #(.HALF(HALF)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .cnt    (cnt_val),
            .wr_cfg (w_cfg),
            .wr_lo  (w_lo),
            .wr_hi  (w_hi),
            .wdata  (bus_wdata),
            .cfg    (ch_cfg[g]),
            .cmp    (ch_cmp[g]),
            .hit    (hit[g])
        );
        assign ch_route[g*RT_W +: RT_W] = ch_cfg[g].route;
    end

    // set beats clear when a match and a one-write land together
    always_comb begin
        st_d = st_q;
        if (wr_gcfg) begin
            st_d.en     = bus_wdata[0];
            st_d.legacy = bus_wdata[1];
        end
        if (wr_sts)
            st_d.sts = st_q.sts & ~bus_wdata[NCH-1:0];
        st_d.sts = st_d.sts | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    evt_irq_route #(.NCH(NCH), .NROUTE(NROUTE)) u_route (
        .sts    (sts_vec),
        .routes (ch_route),
        .cap    (CAP_EFF[NROUTE-1:0]),
        .irq    (irq_route)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADR_ID))
            bus_rdata = ID_WORD;
        else if (bus_addr == AW'(ADR_GCFG))
            bus_rdata = {30'd0, st_q.legacy, st_q.en};
        else if (bus_addr == AW'(ADR_STS))
            bus_rdata = 32'(st_q.sts);
        else if (bus_addr == AW'(ADR_CNT_LO))
            bus_rdata = cnt_val[HALF-1:0];
        else if (bus_addr == AW'(ADR_CNT_HI))
            bus_rdata = cnt_val[2*HALF-1:HALF];
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == AW'(CH_BASE + n * CH_STRIDE + CH_OFS_CFG))
                bus_rdata = cfg_pack(ch_cfg[n]);
            if (bus_addr == AW'(CH_BASE + n * CH_STRIDE + CH_OFS_CAP))
                bus_rdata = CAP_EFF;
            if (bus_addr == AW'(CH_BASE + n * CH_STRIDE + CH_OFS_CLO))
                bus_rdata = ch_cmp[n][HALF-1:0];
            if (bus_addr == AW'(CH_BASE + n * CH_STRIDE + CH_OFS_CHI))
                bus_rdata = ch_cmp[n][2*HALF-1:HALF];
        end
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int NCH    = 3,
    parameter int NROUTE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              cnt_wr_lo,
    input logic              cnt_wr_hi,
    input logic [63:0]       cnt,
    input logic [NCH-1:0]    sts,
    input logic [NCH-1:0]    hit,
    input logic              sts_wr,
    input logic [31:0]       wdata,
    input logic [NROUTE-1:0] irq
);
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr_lo && !cnt_wr_hi) |=> $stable(cnt));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr_lo && !cnt_wr_hi) |=> (cnt == $past(cnt) + 64'd1));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> (|sts));

    for (genvar n = 0; n < NCH; n++) begin : g_sts
        // R6
        sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts[n]) |-> $past(hit[n]));

        // R9
        sts_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts[n]) |-> $past(run));

        // R8
        sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sts[n]) |-> $past(sts_wr && wdata[n]));
    end
endmodule

bind evt_timer_top evt_timer_chk #(.NCH(NCH), .NROUTE(NROUTE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cnt_wr_lo (cnt_wr_lo),
    .cnt_wr_hi (cnt_wr_hi),
    .cnt       (cnt_val),
    .sts       (sts_vec),
    .hit       (hit),
    .sts_wr    (wr_sts),
    .wdata     (bus_wdata),
    .irq       (irq_route)
);

// File: tb/sim_evt_timer_top.sv
`timescale 1ns/1ps
module sim_evt_timer_top;
    localparam logic [31:0] CAP = 32'h0000_00E6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evt_timer_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_route (irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [11:0] chb(input int n);
        return 12'(12'h100 + n * 12'h20);
    endfunction

    task automatic arm(input int n, input logic [31:0] cfgw,
                       input logic [63:0] s, input logic [63:0] c);
        wr(12'h0F0, s[31:0]);
        wr(12'h0F4, s[63:32]);
        wr(chb(n) + 12'h8, c[31:0]);
        wr(chb(n) + 12'hC, c[63:32]);
        wr(chb(n), cfgw);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        logic [63:0] s;
        logic [7:0]  e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(12'h010, v); chk("R12 gcfg", v, 0);
        rd(12'h020, v); chk("R12 status", v, 0);
        rd(12'h0F0, v); chk("R12 cnt lo", v, 0);
        rd(12'h0F4, v); chk("R12 cnt hi", v, 0);
        rd(chb(1), v);  chk("R12 ch cfg", v, 0);
        rd(chb(2) + 12'h8, v); chk("R12 ch cmp", v, 0);
        chk("R12 irq", irq, 0);

        // R1 identifier
        rd(12'h000, v); chk("R1 id", v, 32'h0000_0201);

        // R5 configuration layout and bitmap
        wr(chb(1), 32'h0000_0A22);
        rd(chb(1), v); chk("R5 cfg readback", v, 32'h0000_0A22);
        wr(chb(2), 32'hFFFF_FFFF);
        rd(chb(2), v); chk("R5 cfg mask", v, 32'h0000_3E26);
        wr(chb(2), 32'h0);
        wr(chb(1), 32'h0);
        for (int n = 0; n < 3; n++) begin
            wr(chb(n) + 12'h4, 32'h0);
            rd(chb(n) + 12'h4, v); chk("R5 bitmap", v, CAP);
        end

        // R3 compatibility bit stored only
        wr(12'h010, 32'h2);
        rd(12'h010, v); chk("R3 readback", v, 32'h2);
        rd(12'h0F0, v);
        repeat (5) @(negedge clk);
        rd(12'h0F0, v2); chk("R3 counter idle", v2, v);
        chk("R3 irq", irq, 0);
        wr(12'h010, 32'h0);

        // R2 counting and stopping
        wr(12'h010, 32'h1);
        repeat (7) @(negedge clk);
        rd(12'h0F0, v); chk("R2 count", v, 32'd7);
        wr(12'h010, 32'h0);
        rd(12'h0F0, v); chk("R2 stop", v, 32'd9);
        repeat (6) @(negedge clk);
        rd(12'h0F0, v); chk("R2 hold", v, 32'd9);

        // R4 halves, carry and clear
        wr(12'h0F0, 32'hFFFF_FFFE);
        wr(12'h0F4, 32'h12);
        rd(12'h0F0, v); chk("R4 lo write", v, 32'hFFFF_FFFE);
        rd(12'h0F4, v); chk("R4 hi write", v, 32'h12);
        wr(12'h010, 32'h1);
        repeat (3) @(negedge clk);
        rd(12'h0F0, v); chk("R4 carry lo", v, 32'h1);
        rd(12'h0F4, v); chk("R4 carry hi", v, 32'h13);
        wr(12'h010, 32'h0);
        wr(12'h0F0, 32'h0);
        wr(12'h0F4, 32'h0);
        rd(12'h0F0, v); chk("R4 zero lo", v, 0);
        rd(12'h0F4, v); chk("R4 zero hi", v, 0);

        // R6 R10 R11 sweep of channels and routes
        for (int n = 0; n < 3; n++) begin
            for (int r = 0; r < 8; r++) begin
                logic [31:0] cw;
                cw = (32'(r) << 9) | 32'h6;
                s  = {32'h7, 32'h1000 + 32'(n * 64 + r)};
                e  = CAP[r] ? (8'd1 << r) : 8'd0;
                arm(n, cw, s, s + 64'd3);
                wr(12'h010, 32'h1);
                repeat (3) @(negedge clk);
                rd(12'h020, v); chk("R6 not early", v, 0);
                @(negedge clk);
                rd(12'h020, v); chk("R6 match", v, 32'd1 << n);
                chk(CAP[r] ? "R10 route" : "R11 blocked", irq, e);
                wr(12'h010, 32'h0);
                chk("R10 held", irq, e);
                wr(12'h020, 32'd1 << n);
                rd(12'h020, v); chk("R8 clear", v, 0);
                chk("R10 released", irq, 0);
                wr(chb(n), cw & ~32'h4);
            end
        end

        // R7 low-word compare ignores upper half
        arm(0, 32'h0000_0224, {32'h1, 32'h50}, {32'h9, 32'h53});
        wr(12'h010, 32'h1);
        repeat (4) @(negedge clk);
        rd(12'h020, v); chk("R7 m32 match", v, 32'h1);
        chk("R7 irq", irq, 8'h02);
        wr(12'h010, 32'h0);
        wr(12'h020, 32'h1);
        arm(0, 32'h0000_0204, {32'h1, 32'h50}, {32'h9, 32'h53});
        wr(12'h010, 32'h1);
        repeat (8) @(negedge clk);
        rd(12'h020, v); chk("R7 64-bit no match", v, 0);
        wr(12'h010, 32'h0);
        arm(0, 32'h0000_0224, {32'h3, 32'hFFFF_FFFE}, {32'h0, 32'h1});
        wr(12'h010, 32'h1);
        repeat (3) @(negedge clk);
        rd(12'h020, v); chk("R7 wrap early", v, 0);
        @(negedge clk);
        rd(12'h020, v); chk("R7 wrap match", v, 32'h1);
        wr(12'h010, 32'h0);
        wr(12'h020, 32'h1);
        wr(chb(0), 32'h0);

        // R9 disabled channel keeps settings, raises nothing
        arm(1, 32'h0000_0404, {32'h0, 32'h200}, {32'h0, 32'h203});
        wr(12'h010, 32'h1);
        repeat (4) @(negedge clk);
        rd(12'h020, v); chk("R9 armed match", v, 32'h2);
        chk("R9 armed irq", irq, 8'h04);
        wr(12'h010, 32'h0);
        wr(12'h020, 32'h2);
        wr(chb(1), 32'h0000_0400);
        rd(chb(1), v); chk("R9 route kept", v, 32'h0000_0400);
        rd(chb(1) + 12'h8, v); chk("R9 compare kept", v, 32'h203);
        wr(12'h0F0, 32'h200);
        wr(12'h010, 32'h1);
        repeat (8) @(negedge clk);
        rd(12'h020, v); chk("R9 disabled status", v, 0);
        chk("R9 disabled irq", irq, 0);
        wr(12'h010, 32'h0);

        // R8 write-one-to-clear with two channels pending
        arm(0, 32'h0000_0204, {32'h0, 32'h300}, {32'h0, 32'h303});
        arm(2, 32'h0000_0C04, {32'h0, 32'h300}, {32'h0, 32'h303});
        wr(12'h010, 32'h1);
        repeat (4) @(negedge clk);
        rd(12'h020, v); chk("R8 both set", v, 32'h5);
        chk("R10 two routes", irq, 8'h42);
        wr(12'h010, 32'h0);
        wr(12'h020, 32'h0);
        rd(12'h020, v); chk("R8 zero write", v, 32'h5);
        wr(12'h020, 32'h4);
        rd(12'h020, v); chk("R8 partial clear", v, 32'h1);
        chk("R10 remaining route", irq, 8'h02);
        wr(12'h020, 32'h1);
        rd(12'h020, v); chk("R8 all clear", v, 0);
        chk("R10 none", irq, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule